// File: doc/BRIEF.md
# Unaligned Load Merge Unit

This block carries out the four partial-register load operations of a 64-bit core: word-left, word-right, doubleword-left and doubleword-right. A request brings an opcode, an effective byte address, the old contents of the destination register and an endianness select. The unit fetches the naturally aligned word or doubleword that holds the addressed byte with a single read, then moves the fetched bytes into place with one shift and keeps the untouched register bytes with a mask. The mask starts from a constant that is already shifted by one bit, so no shift ever spans the full data width.

The controller is a four-state machine. `IDLE` holds the request port ready. The transition *accept* (valid while ready) goes to `ISSUE`, which raises the read strobe with the aligned address. The transition *issued* goes unconditionally to `CAPTURE`, the cycle in which the fixed one-cycle read latency delivers the data and the merged value is registered. The transition *merged* goes to `DONE`, which pulses the done strobe and shows the result. The transition *retire* returns to `IDLE`.

Top module: `ulm_top`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and `mem_rd` is 0; `req_ready` is 1 only in the idle state, and a request is taken on a rising edge where `req_valid` and `req_ready` are both 1.
- R2: Each taken request causes exactly one read: `mem_rd` is 1 for the single cycle after acceptance, with `mem_addr` equal to the request address with its low 2 bits (word) or low 3 bits (doubleword) cleared and `mem_dword` equal to `req_op[1]`.
- R3: `mem_rdata` is sampled in the cycle after the read strobe; `done` is 1 for exactly one cycle, two cycles after the read strobe, and `result` is valid while `done` is 1.
- R4: Opcodes are `req_op` = 00 word-left, 01 word-right, 10 doubleword-left, 11 doubleword-right. The byte offset k is the low 2 (word) or 3 (doubleword) address bits; it is inverted (XOR 3 or XOR 7) for left operations when `req_big_endian` = 0 and for right operations when `req_big_endian` = 1.
- R5: A left operation with N-byte width places fetched byte i into register byte i+k for i < N-k and keeps register bytes below k.
- R6: A right operation places fetched byte i+k into register byte i for i < N-k and keeps register bytes from N-k upward.
- R7: Word operations use only `mem_rdata[31:0]` and bits 31..0 of the old value; result bits 63..32 are copies of result bit 31 for both word operations.
- R8: With k = 0 both left and right operations replace the whole word or doubleword; with k = N-1 a right operation keeps all but the lowest register byte and a left operation keeps all but the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 2 | Operation select (see R4) |
| req_addr | input | AW | Effective byte address |
| req_old | input | 64 | Old destination register value |
| req_big_endian | input | 1 | 1 = big-endian byte order |
| mem_rd | output | 1 | Aligned read strobe |
| mem_addr | output | AW | Aligned read address |
| mem_dword | output | 1 | 1 = doubleword read, 0 = word read |
| mem_rdata | input | 64 | Read data, one cycle after the strobe |
| done | output | 1 | Result strobe |
| result | output | 64 | Merged register value |

## Verification
Every opcode is run at every byte offset under both byte orders with random fetched data and random old register values, and compared with a byte-by-byte placement model; this separates a wrong offset inversion from a wrong shift or mask, since each (order, offset) pair moves a different byte count. Word operations are also run with all-ones and random upper register halves and junk in the upper data lanes, which exposes any leak of stale upper bytes or missing sign extension. Fixed patterns at offsets 0 and N-1 pin down the full-replace and single-byte edges, and each request checks the strobe, address alignment and done timing.

// File: rtl/ulm_pkg.sv
package ulm_pkg;
    localparam int XLEN = 64;
    localparam int WLEN = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [1:0] {
        OP_WL = 2'b00,
        OP_WR = 2'b01,
        OP_DL = 2'b10,
        OP_DR = 2'b11
    } ulm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_ISSUE   = 2'b01,
        ST_CAPTURE = 2'b10,
        ST_DONE    = 2'b11
    } ulm_state_e;
endpackage

// File: rtl/ulm_shift_ctl.sv
module ulm_shift_ctl #(
    parameter int AW = 32
) (
    input  logic [1:0]               op,
    input  logic [AW-1:0]            addr,
    input  logic                     big_endian,
    output logic [ulm_pkg::SHW-1:0]  shamt,
    output logic [AW-1:0]            aligned
);
    logic       is_dbl;
    logic       is_right;
    logic [2:0] raw_off;
    logic [2:0] adj_off;
    logic [2:0] flip;

    always_comb begin
        is_dbl   = op[1];
        is_right = op[0];
        raw_off  = is_dbl ? addr[2:0] : {1'b0, addr[1:0]};
        flip     = is_dbl ? 3'd7 : 3'd3;
        adj_off  = (is_right == big_endian) ? (raw_off ^ flip) : raw_off;
        shamt    = {adj_off, 3'b000};
        aligned  = is_dbl ? {addr[AW-1:3], 3'b000} : {addr[AW-1:2], 2'b00};
    end
endmodule

// File: rtl/ulm_merge.sv
module ulm_merge (
    input  logic [1:0]                op,
    input  logic [ulm_pkg::SHW-1:0]   shamt,
    input  logic [ulm_pkg::XLEN-1:0]  fetched,
    input  logic [ulm_pkg::XLEN-1:0]  old_val,
    output logic [ulm_pkg::XLEN-1:0]  merged
);
    import ulm_pkg::*;

    localparam logic [XLEN-1:0] DL_SEED = {1'b0, {(XLEN-1){1'b1}}};
    localparam logic [XLEN-1:0] DR_SEED = {{(XLEN-1){1'b1}}, 1'b0};
    localparam logic [WLEN-1:0] WL_SEED = {1'b0, {(WLEN-1){1'b1}}};
    localparam logic [WLEN-1:0] WR_SEED = {{(WLEN-1){1'b1}}, 1'b0};

    logic [SHW-2:0]  wsh;
    logic [WLEN-1:0] wdata, wold, wkeep, wout;
    logic [XLEN-1:0] dkeep, dout;

    always_comb begin
        wsh   = shamt[SHW-2:0];
        wdata = fetched[WLEN-1:0];
        wold  = old_val[WLEN-1:0];
        if (op[0]) begin
            wkeep = WR_SEED << (wsh ^ 5'd31);
            wout  = (wdata >> wsh) | (wold & wkeep);
            dkeep = DR_SEED << (shamt ^ 6'd63);
            dout  = (fetched >> shamt) | (old_val & dkeep);
        end else begin
            wkeep = WL_SEED >> (wsh ^ 5'd31);
            wout  = (wdata << wsh) | (wold & wkeep);
            dkeep = DL_SEED >> (shamt ^ 6'd63);
            dout  = (fetched << shamt) | (old_val & dkeep);
        end
        merged = op[1] ? dout : {{WLEN{wout[WLEN-1]}}, wout};
    end
endmodule

// File: rtl/ulm_top.sv
module ulm_top #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [63:0]   req_old,
    input  logic          req_big_endian,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          mem_dword,
    input  logic [63:0]   mem_rdata,
    output logic          done,
    output logic [63:0]   result
);
    import ulm_pkg::*;

    ulm_state_e      state, state_nx;
    logic [1:0]      op_q;
    logic [AW-1:0]   addr_q;
    logic [XLEN-1:0] old_q, res_q;
    logic            big_q;
    logic [SHW-1:0]  shamt;
    logic [AW-1:0]   aligned;
    logic [XLEN-1:0] merged;

    ulm_shift_ctl #(.AW(AW)) u_shift (
        .op(op_q), .addr(addr_q), .big_endian(big_q),
        .shamt(shamt), .aligned(aligned)
    );

    ulm_merge u_merge (
        .op(op_q), .shamt(shamt), .fetched(mem_rdata),
        .old_val(old_q), .merged(merged)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = ST_ISSUE;
            ST_ISSUE:   state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= 2'b00;
            addr_q <= '0;
            old_q  <= '0;
            big_q  <= 1'b0;
            res_q  <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                op_q   <= req_op;
                addr_q <= req_addr;
                old_q  <= req_old;
                big_q  <= req_big_endian;
            end
            if (state == ST_CAPTURE) res_q <= merged;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        mem_rd    = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_ISSUE:   mem_rd    = 1'b1;
            ST_CAPTURE: ;
            ST_DONE:    done      = 1'b1;
        endcase
        mem_addr  = aligned;
        mem_dword = op_q[1];
        result    = res_q;
    end

    // R1: no new request while a previous one is in flight
    p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R2: acceptance leads to the strobe on the next cycle
    p_read_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd);
    // R2: strobe lasts one cycle
    p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // R2: read address is aligned to the access size
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[1:0] == 2'b00 && (!mem_dword || mem_addr[2] == 1'b0)));
    // R3: done two cycles after the strobe, one cycle wide
    p_done_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ##2 done);
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: word results are sign-extended
    p_word_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mem_dword) |-> (result[63:32] == {32{result[31]}}));
    // R8: zero offset replaces the whole access width
    p_full_replace_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && shamt == '0) |->
        (merged == (op_q[1] ? mem_rdata : {{32{mem_rdata[31]}}, mem_rdata[31:0]})));
endmodule

// File: tb/tb_ulm_top.sv
module tb_ulm_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_old = '0;
    logic          req_big_endian = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic          mem_dword;
    logic [63:0]   mem_rdata = '0;
    logic          done;
    logic [63:0]   result;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ulm_top #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_old(req_old),
        .req_big_endian(req_big_endian), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_dword(mem_dword), .mem_rdata(mem_rdata), .done(done), .result(result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_model(input logic [1:0] op, input logic [AW-1:0] a,
                                              input logic big, input logic [63:0] old,
                                              input logic [63:0] data);
        int n = op[1] ? 8 : 4;
        int off = op[1] ? int'(a[2:0]) : int'(a[1:0]);
        int k = (op[0] == big) ? (off ^ (n - 1)) : off;
        logic [63:0] r = old;
        if (op[0] == 1'b0) begin
            for (int j = k; j < n; j++) r[j*8 +: 8] = data[(j-k)*8 +: 8];
        end else begin
            for (int j = 0; j < n - k; j++) r[j*8 +: 8] = data[(j+k)*8 +: 8];
        end
        if (!op[1]) r[63:32] = {32{r[31]}};
        return r;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic big,
                          input logic [63:0] old, input logic [63:0] data, input string tag);
        logic [AW-1:0] al;
        al = op[1] ? {a[AW-1:3], 3'b000} : {a[AW-1:2], 2'b00};
        @(negedge clk);
        check("R1 ready idle", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_op = op; req_addr = a; req_big_endian = big; req_old = old;
        @(negedge clk);
        req_valid = 1'b0; req_old = ~old;
        check("R2 strobe", {63'd0, mem_rd}, 64'd1);
        check("R2 address", {32'd0, mem_addr}, {32'd0, al});
        check("R2 size", {63'd0, mem_dword}, {63'd0, op[1]});
        check("R1 busy", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
        check("R2 single strobe", {63'd0, mem_rd}, 64'd0);
        check("R3 no early done", {63'd0, done}, 64'd0);
        mem_rdata = data;
        @(negedge clk);
        mem_rdata = $urandom();
        check("R3 done", {63'd0, done}, 64'd1);
        check(tag, result, ref_model(op, a, big, old, data));
        @(negedge clk);
        check("R3 done pulse", {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 reset ready", {63'd0, req_ready}, 64'd1);
        check("R1 reset done", {63'd0, done}, 64'd0);
        check("R1 reset strobe", {63'd0, mem_rd}, 64'd0);
    endtask

    task automatic t_sweep(input logic dbl);
        for (int big = 0; big < 2; big++)
            for (int rt = 0; rt < 2; rt++)
                for (int off = 0; off < (dbl ? 8 : 4); off++) begin
                    logic [AW-1:0] a = {$urandom()} & ~32'h7 | off;
                    run_op({dbl, rt[0]}, a, big[0], {$urandom(), $urandom()},
                           {$urandom(), $urandom()}, rt ? "R6 R4 right merge" : "R5 R4 left merge");
                end
    endtask

    task automatic t_upper_half();
        for (int op = 0; op < 2; op++)
            for (int off = 0; off < 4; off++) begin
                run_op(op[1:0], 32'h100 | off, 1'b0, 64'hFFFF_FFFF_0000_0000,
                       {32'hDEAD_BEEF, 32'h0123_4567}, "R7 stale upper ones");
                run_op(op[1:0], 32'h200 | off, 1'b1, {$urandom(), 32'h0},
                       {$urandom(), 32'h89AB_CDEF}, "R7 random upper");
            end
    endtask

    task automatic t_corners();
        // little-endian left at offset 3 -> k=0: full word replace
        run_op(2'b00, 32'h13, 1'b0, 64'h1111_1111_2222_2222, 64'h0000_0000_8765_4321, "R8 word left full");
        check("R8 word left value", result, 64'hFFFF_FFFF_8765_4321);
        // little-endian right at offset 0 -> k=0: full doubleword replace
        run_op(2'b11, 32'h20, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0102_0304_0506_0708, "R8 dword right full");
        check("R8 dword right value", result, 64'h0102_0304_0506_0708);
        // little-endian right at offset 7 -> k=7: one byte loaded
        run_op(2'b11, 32'h27, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5500_0000_0000_0000, "R8 dword right one byte");
        check("R8 dword right byte", result, 64'hAAAA_AAAA_AAAA_AA55);
        // little-endian left at offset 0 -> k=7: only top byte replaced
        run_op(2'b10, 32'h30, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_0066, "R8 dword left one byte");
        check("R8 dword left byte", result, 64'h66AA_AAAA_AAAA_AAAA);
        // big-endian word right at offset 3 -> k=0: full replace, positive sign
        run_op(2'b01, 32'h43, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_1234_5678, "R8 word right full");
        check("R8 word right value", result, 64'h0000_0000_1234_5678);
    endtask

    initial begin
        fork
            begin
                t_reset();
                #12 rst_n = 1'b1;
                t_reset();
                t_sweep(1'b0);
                t_sweep(1'b1);
                t_upper_half();
                t_corners();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=timeout exp=finish");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule